// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block adds two wide operands lane by lane. Each operand is cut into independent lanes of 8 or 16 bits, and each lane of one operand is added only to the lane at the same position in the other operand. No carry crosses from one lane into the next. Per operation, a lane can be read as unsigned or as two's-complement signed. Each lane either wraps to its low bits or clamps to the lane's extreme value.

Every lane reports an overflow flag whenever the true sum falls outside the lane's range. This holds in both the wrapping and the clamping modes. The sum and the flags are captured into output registers one cycle after a valid request. Typical uses are audio or pixel arithmetic and other packed-integer datapaths in which a wrap-around value would be harmful.

Top module: `sat_lane_adder`

## Requirements
- R1: While rst_ni is low, out_valid_o, result_o and ovf_o are all zero.
- R2: out_valid_o is high exactly in the cycle after in_valid_i was sampled high. result_o and ovf_o change only in that cycle and otherwise hold their values.
- R3: With lane_sel_i = 0, the operands form DATA_W/8 lanes, where lane i occupies bits [8i+7:8i]. Each lane is computed from its own bits only.
- R4: With lane_sel_i = 1, the operands form DATA_W/16 lanes, where lane i occupies bits [16i+15:16i]. No carry crosses a lane boundary.
- R5: With sat_i = 0 (wrap), a lane result is the low lane-width bits of the sum. For example, unsigned 8-bit 210 + 83 gives 37.
- R6: With signed_i = 0, a lane's flag is set when the true sum exceeds 2^W - 1, in either mode.
- R7: With signed_i = 1, a lane's flag is set when both addends have the same sign bit and the wrapped sum has the other sign bit, in either mode.
- R8: With sat_i = 1 and signed_i = 0, an overflowing lane gives all ones (255 for 8-bit lanes).
- R9: With sat_i = 1 and signed_i = 1, a positive overflow gives the lane maximum (0x7F / 0x7FFF) and a negative overflow gives the lane minimum (0x80 / 0x8000).
- R10: Bit i of ovf_o belongs to lane i. With lane_sel_i = 1, bits DATA_W/16 and above are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request |
| lane_sel_i | input | 1 | 0: 8-bit lanes, 1: 16-bit lanes |
| signed_i | input | 1 | 1: signed lane range |
| sat_i | input | 1 | 0: wrap, 1: saturate |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| out_valid_o | output | 1 | Result registered this cycle |
| result_o | output | DATA_W | Packed lane sums |
| ovf_o | output | DATA_W/8 | Per-lane overflow flags |

## Verification
The bench builds the block with DATA_W = 32, which gives four byte lanes or two halfword lanes. At that width, the byte lanes can cover all 65536 addend pairs in 16384 requests for each of the four sign and saturation combinations. The halfword mode is run with its boundary pairs and a long deterministic sweep, under every combination. Cycles with no request and changing data are placed between requests to show that the outputs hold.

// File: rtl/sat_lane_adder_pkg.sv
package sat_lane_adder_pkg;
  typedef enum logic {
    LANE_8  = 1'b0,
    LANE_16 = 1'b1
  } lane_size_e;

  localparam int unsigned MinLaneW = 8;
endpackage

// File: rtl/lane_add.sv
module lane_add #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         signed_i,
  input  logic         sat_i,
  output logic [W-1:0] res_o,
  output logic         ovf_o
);
  logic [W:0]   sum_ext;
  logic [W-1:0] wrap;
  logic         ovf_u, ovf_s;
  logic [W-1:0] clamp;

  assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
  assign wrap    = sum_ext[W-1:0];
  assign ovf_u   = sum_ext[W];
  assign ovf_s   = (a_i[W-1] == b_i[W-1]) && (wrap[W-1] != a_i[W-1]);

  always_comb begin
    if (!signed_i)      clamp = '1;
    else if (a_i[W-1])  clamp = {1'b1, {(W-1){1'b0}}};
    else                clamp = {1'b0, {(W-1){1'b1}}};
  end

  assign ovf_o = signed_i ? ovf_s : ovf_u;
  assign res_o = (sat_i && ovf_o) ? clamp : wrap;
endmodule

// File: rtl/lane_array.sv
module lane_array #(
  parameter int unsigned DATA_W = 128,
  parameter int unsigned LANE_W = 8,
  parameter int unsigned FLAG_W = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              signed_i,
  input  logic              sat_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] ovf_o
);
  localparam int unsigned NumLanes = DATA_W / LANE_W;

  logic [NumLanes-1:0] lane_ovf;

  for (genvar l = 0; l < NumLanes; l++) begin : g_lane
    lane_add #(.W(LANE_W)) u_lane (
      .a_i     (a_i[l*LANE_W +: LANE_W]),
      .b_i     (b_i[l*LANE_W +: LANE_W]),
      .signed_i(signed_i),
      .sat_i   (sat_i),
      .res_o   (res_o[l*LANE_W +: LANE_W]),
      .ovf_o   (lane_ovf[l])
    );
  end

  if (NumLanes < FLAG_W) begin : g_pad
    assign ovf_o = {{(FLAG_W-NumLanes){1'b0}}, lane_ovf};
  end else begin : g_full
    assign ovf_o = lane_ovf;
  end
endmodule

// File: rtl/sat_lane_adder.sv
module sat_lane_adder
  import sat_lane_adder_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         in_valid_i,
  input  logic                         lane_sel_i,
  input  logic                         signed_i,
  input  logic                         sat_i,
  input  logic [DATA_W-1:0]            a_i,
  input  logic [DATA_W-1:0]            b_i,
  output logic                         out_valid_o,
  output logic [DATA_W-1:0]            result_o,
  output logic [DATA_W/MinLaneW-1:0]   ovf_o
);
  localparam int unsigned FlagW = DATA_W / MinLaneW;

  lane_size_e        lane_size;
  logic [DATA_W-1:0] res8, res16, res_d;
  logic [FlagW-1:0]  ovf8, ovf16, ovf_d;

  assign lane_size = lane_size_e'(lane_sel_i);

  lane_array #(.DATA_W(DATA_W), .LANE_W(MinLaneW), .FLAG_W(FlagW)) u_byte (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sat_i(sat_i),
    .res_o(res8), .ovf_o(ovf8)
  );

  lane_array #(.DATA_W(DATA_W), .LANE_W(2*MinLaneW), .FLAG_W(FlagW)) u_half (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i), .sat_i(sat_i),
    .res_o(res16), .ovf_o(ovf16)
  );

  assign res_d = (lane_size == LANE_16) ? res16 : res8;
  assign ovf_d = (lane_size == LANE_16) ? ovf16 : ovf8;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      ovf_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        result_o <= res_d;
        ovf_o    <= ovf_d;
      end
    end
  end
endmodule

// File: rtl/sat_lane_adder_chk.sv
module sat_lane_adder_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                lane_sel_i,
  input logic                signed_i,
  input logic                sat_i,
  input logic [DATA_W-1:0]   a_i,
  input logic [DATA_W-1:0]   b_i,
  input logic                out_valid_o,
  input logic [DATA_W-1:0]   result_o,
  input logic [DATA_W/8-1:0] ovf_o
);
  localparam int unsigned FlagW = DATA_W / 8;
  localparam int unsigned HalfLanes = DATA_W / 16;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!out_valid_o && result_o == '0 && ovf_o == '0)); // R1

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (out_valid_o == $past(in_valid_i))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(in_valid_i)) |-> ($stable(result_o) && $stable(ovf_o))); // R2

  AST_UNSIGNED_WRAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_valid_i && !lane_sel_i && !signed_i &&
      (({1'b0, a_i[7:0]} + {1'b0, b_i[7:0]}) > 9'd255))) |-> ovf_o[0]); // R6

  AST_UNSIGNED_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_valid_i && !lane_sel_i && !signed_i && sat_i &&
      (({1'b0, a_i[7:0]} + {1'b0, b_i[7:0]}) > 9'd255))) |-> (result_o[7:0] == 8'hFF)); // R8

  AST_HALF_FLAGS_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(in_valid_i && lane_sel_i)) |-> (ovf_o[FlagW-1:HalfLanes] == '0)); // R10
endmodule

bind sat_lane_adder sat_lane_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .lane_sel_i(lane_sel_i),
  .signed_i(signed_i), .sat_i(sat_i), .a_i(a_i), .b_i(b_i),
  .out_valid_o(out_valid_o), .result_o(result_o), .ovf_o(ovf_o)
);

// File: tb/sat_lane_adder_bench.sv
module sat_lane_adder_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned FW = DW / 8;
  localparam time ClkPeriod = 10ns;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          lane_sel_i = 1'b0;
  logic          signed_i = 1'b0;
  logic          sat_i = 1'b0;
  logic [DW-1:0] a_i = '0;
  logic [DW-1:0] b_i = '0;
  logic          out_valid_o;
  logic [DW-1:0] result_o;
  logic [FW-1:0] ovf_o;

  int n_checks = 0;
  int n_fails = 0;
  logic [DW-1:0] exp_res = '0;
  logic [FW-1:0] exp_ovf = '0;

  always #(ClkPeriod/2) clk_i = ~clk_i;

  sat_lane_adder #(.DATA_W(DW)) u_sat_lane_adder (.*);

  task automatic check(input string tag, input logic exp_v);
    n_checks++;
    if (out_valid_o !== exp_v || result_o !== exp_res || ovf_o !== exp_ovf) begin
      n_fails++;
      $display("FAIL %s: got v=%0b res=%h ovf=%b exp v=%0b res=%h ovf=%b",
               tag, out_valid_o, result_o, ovf_o, exp_v, exp_res, exp_ovf);
    end
  endtask

  // Arithmetic model of one lane of width w
  task automatic model_lane(input int a, input int b, input int w, input bit sg, input bit st,
                            output int r, output bit ov);
    int lim, s, sa, sb;
    lim = 1 << w;
    if (!sg) begin
      s  = a + b;
      ov = (s > lim - 1);
      r  = (st && ov) ? lim - 1 : s % lim;
    end else begin
      sa = (a >= lim/2) ? a - lim : a;
      sb = (b >= lim/2) ? b - lim : b;
      s  = sa + sb;
      ov = (s > lim/2 - 1) || (s < -(lim/2));
      if (st && s > lim/2 - 1)   r = lim/2 - 1;
      else if (st && s < -(lim/2)) r = lim/2;
      else                        r = ((s % lim) + lim) % lim;
    end
  endtask

  task automatic step(input string tag, input logic v, input logic ls, input logic sg,
                      input logic st, input logic [DW-1:0] a, input logic [DW-1:0] b);
    int w, nl, r;
    bit ov;
    in_valid_i = v; lane_sel_i = ls; signed_i = sg; sat_i = st; a_i = a; b_i = b;
    if (v) begin
      w  = ls ? 16 : 8;
      nl = DW / w;
      exp_res = '0;
      exp_ovf = '0;
      for (int l = 0; l < nl; l++) begin
        model_lane(int'((a >> (l*w)) & ((DW'(1) << w) - 1)),
                   int'((b >> (l*w)) & ((DW'(1) << w) - 1)), w, sg, st, r, ov);
        exp_res = exp_res | (DW'(r) << (l*w));
        exp_ovf[l] = ov;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag, v);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] a, b;
    logic [15:0] ha, hb;
    repeat (3) @(negedge clk_i);
    check("R1 reset", 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 explicit: unsigned 210+83 wraps to 37, lane 0
    step("R5 210+83", 1, 0, 0, 0, 32'd210, 32'd83);
    // R2: idle cycles with changing data must hold outputs
    step("R2 hold", 0, 1, 1, 1, 32'hFFFF_FFFF, 32'h7F7F_7F7F);
    step("R2 hold", 0, 0, 0, 1, 32'h1234_5678, 32'h9ABC_DEF0);

    // Byte lanes: all 65536 pairs, four lanes per request, every mode (R3)
    for (int m = 0; m < 4; m++) begin
      string tag;
      case (m)
        0: tag = "R3 R5 R6 byte unsigned wrap";
        1: tag = "R3 R5 R7 byte signed wrap";
        2: tag = "R3 R6 R8 byte unsigned sat";
        default: tag = "R3 R7 R9 byte signed sat";
      endcase
      for (int x = 0; x < 16384; x++) begin
        for (int l = 0; l < 4; l++) begin
          a[8*l +: 8] = 8'((x*4 + l) >> 8);
          b[8*l +: 8] = 8'(x*4 + l);
        end
        step(tag, 1, 0, m[0], m[1], a, b);
        if (x % 4096 == 4095) step("R2 idle hold", 0, 0, 0, 0, ~a, ~b);
      end
    end

    // Halfword lanes: corners then deterministic sweep (R4, R10)
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 1500; k++) begin
        case (k)
          0: begin ha = 16'h7FFF; hb = 16'h0001; end
          1: begin ha = 16'h8000; hb = 16'h8000; end
          2: begin ha = 16'hFFFF; hb = 16'h0001; end
          3: begin ha = 16'hFFFF; hb = 16'hFFFF; end
          4: begin ha = 16'h00FF; hb = 16'h0001; end  // carry across byte inside lane
          5: begin ha = 16'h8000; hb = 16'hFFFF; end
          default: begin ha = 16'(k * 40503); hb = 16'(k * 9973 + 12345); end
        endcase
        a = {16'(ha * 3 + 16'h0101), ha};
        b = {16'(hb ^ 16'hA5A5), hb};
        step(m[1] ? (m[0] ? "R4 R9 R10 half signed sat" : "R4 R8 R10 half unsigned sat")
                  : (m[0] ? "R4 R7 R10 half signed wrap" : "R4 R6 R10 half unsigned wrap"),
             1, 1, m[0], m[1], a, b);
      end
    end

    // R4: 0x00FF+0x0001 in halfword lane must not match two independent byte lanes
    step("R4 carry inside lane", 1, 1, 0, 0, 32'h00FF_00FF, 32'h0001_0001);
    step("R3 carry cut at byte", 1, 0, 0, 0, 32'h00FF_00FF, 32'h0001_0001);
    step("R2 final hold", 0, 1, 0, 0, 32'h0, 32'h0);

    rst_ni = 1'b0;
    #1;
    exp_res = '0;
    exp_ovf = '0;
    check("R1 async reset", 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule